// File: doc/BRIEF.md
# Triggered acquisition control sequencer

This block steers one data-acquisition measurement at a time on behalf of a host processor. The processor programs a control register and a pretrigger sample count through a simple register write port. It then pulses a start request. In free-run mode the sequencer goes straight to waiting for the capture buffer to fill. In triggered mode it first consumes a programmed number of samples. It then pulls an active-low arm line to an external trigger source and waits for that source to answer with a buffer-start pulse. After that it waits for the buffer to report full.

The buffer-full indication arrives from another clock domain. It is resynchronized and edge-detected, so one fill produces one completion. On completion a block-ready interrupt line rises and stays high until the processor writes an acknowledge. Only then is a new start accepted. A status byte, driven only while a read strobe is high, carries a sticky not-real-time overrun flag and a copy of the block-ready line.

Samples arrive on a valid/ready stream that carries no payload. A sample is taken on a cycle where both valid and ready are high. Ready is high only while a measurement is running, that is from start until completion. In idle, and while the interrupt waits for acknowledge, ready is low and the source must hold its samples back. Samples offered while ready is low are not counted.

Top module: `acq_sequencer`

## Requirements
- R1: A write with `cfg_addr`=0 loads the control bits: bit 3 enable, bit 2 pretrigger enable, bit 1 triggered mode. Bit 0 is an acknowledge action and is not stored. Writes to addresses 1 and 2 load the low and high byte of the 16-bit pretrigger count. Writes to any other address leave the control bits unchanged.
- R2: A start request is accepted only in idle and only while the enable bit is set. Otherwise it has no effect, and `smp_ready` stays low.
- R3: In free-run mode `arm_n` is never asserted. From the cycle after start, `smp_ready` is high and the sequencer waits only for buffer-full. `buf_start` has no effect in this mode.
- R4: In triggered mode with pretrigger enabled and a non-zero count N, `arm_n` stays high and `buf_start` is ignored until N samples have been taken after start. `arm_n` goes low in the cycle after the handshake that delivers the Nth sample.
- R5: In triggered mode with pretrigger disabled, or with a count of 0, `arm_n` goes low in the cycle after start.
- R6: While armed, a buffer-full edge has no effect. A `buf_start` pulse releases `arm_n` in the next cycle and the sequencer begins waiting for buffer-full.
- R7: `buf_full` passes through a two-flop synchronizer and a rising-edge detector. A rising edge driven before clock edge k makes `blk_ready` high after edge k+2 and not earlier. A level that is already high when waiting begins does not complete the measurement.
- R8: `blk_ready` stays high, and start requests are ignored, until a write to address 0 with bit 0 set. After that write the sequencer is idle.
- R9: `smp_ready` is high only while a measurement is running. Samples offered while it is low are not counted toward the pretrigger count.
- R10: While `stat_rd` is high, `stat_rdata` carries the overrun flag in bit 0 and `blk_ready` in bit 1, with all other bits 0. While `stat_rd` is low, `stat_rdata` is 0.
- R11: The overrun flag sets in the cycle after `overrun` is high. A status read clears it after the read cycle, unless `overrun` is high in that same cycle, in which case it stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address (0 control, 1 count low byte, 2 count high byte) |
| cfg_wdata | input | 8 | Register write data |
| stat_rd | input | 1 | Status read strobe |
| stat_rdata | output | 8 | Status byte, zero outside a read |
| start_req | input | 1 | Measurement start request |
| smp_valid | input | 1 | Sample stream valid |
| smp_ready | output | 1 | Sample stream ready |
| arm_n | output | 1 | Active-low arm line to the trigger source |
| buf_start | input | 1 | Buffer-start answer from the trigger source |
| buf_full | input | 1 | Asynchronous buffer-full indication |
| blk_ready | output | 1 | Block-ready interrupt |
| overrun | input | 1 | Not-real-time overrun condition |

## Verification
The sequence is run in free-run mode, in triggered mode with a three-sample pretrigger, in triggered mode with pretrigger disabled, and with pretrigger enabled but a count of zero. These runs separate the three entry paths out of idle, and they show whether the sample counter gates arming. Trigger-source answers and buffer-full edges are injected too early, while still counting or while merely armed, to show that the sequencer ignores them. A buffer-full level that is already high at start, followed by a genuine edge, separates edge detection from level detection and fixes the synchronizer latency. Overrun pulses placed before, during and after status reads tell a flag with set priority apart from a plain clear-on-read flag.

// File: rtl/acq_pkg.sv
package acq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_PRE   = 3'd1,
    ST_ARMED = 3'd2,
    ST_FILL  = 3'd3,
    ST_DONE  = 3'd4
  } acq_state_e;

  // control word bit positions (address 0)
  localparam int CTRL_ACK_BIT  = 0;
  localparam int CTRL_TRIG_BIT = 1;
  localparam int CTRL_PRE_BIT  = 2;
  localparam int CTRL_EN_BIT   = 3;

  // status byte bit positions
  localparam int STAT_NRT_BIT  = 0;
  localparam int STAT_BLK_BIT  = 1;

  typedef struct packed {
    logic en;
    logic pre;
    logic trig;
  } acq_mode_t;

endpackage

// File: rtl/acq_cmd_regs.sv
module acq_cmd_regs
  import acq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16,
  parameter int NBYTES = 2,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output acq_mode_t         mode,
  output logic [CNT_W-1:0]  pre_cnt,
  output logic              ack
);

  logic ctrl_sel;
  assign ctrl_sel = wr && (addr == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode <= '0;
    end else if (ctrl_sel) begin
      mode.en   <= wdata[CTRL_EN_BIT];
      mode.pre  <= wdata[CTRL_PRE_BIT];
      mode.trig <= wdata[CTRL_TRIG_BIT];
    end
  end

  assign ack = ctrl_sel && wdata[CTRL_ACK_BIT];

  // one register segment per count byte
  for (genvar g = 0; g < NBYTES; g++) begin : g_cnt_byte
    localparam int LO = g * DATA_W;
    localparam int SW = ((CNT_W - LO) < DATA_W) ? (CNT_W - LO) : DATA_W;
    logic [SW-1:0] seg_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        seg_q <= '0;
      end else if (wr && (addr == ADDR_W'(g + 1))) begin
        seg_q <= wdata[SW-1:0];
      end
    end
    assign pre_cnt[LO +: SW] = seg_q;
  end

  AST_MODE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr != '0) |=> $stable(mode)); // R1

endmodule

// File: rtl/acq_sync_edge.sv
module acq_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);

  // STAGES synchronizer flops plus one history flop for the edge
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-1:0], async_in};
    end
  end

  assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise); // R7

endmodule

// File: rtl/acq_status.sv
module acq_status
  import acq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              overrun,
  input  logic              rd,
  input  logic              blk_ready,
  output logic [DATA_W-1:0] rdata
);

  logic nrt_q;
  logic [DATA_W-1:0] word;

  // set has priority over the clear that a read causes
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nrt_q <= 1'b0;
    end else if (overrun) begin
      nrt_q <= 1'b1;
    end else if (rd) begin
      nrt_q <= 1'b0;
    end
  end

  always_comb begin
    word = '0;
    word[STAT_NRT_BIT] = nrt_q;
    word[STAT_BLK_BIT] = blk_ready;
  end

  assign rdata = rd ? word : '0;

  AST_NRT_SET:   assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> nrt_q); // R11
  AST_NRT_HOLD:  assert property (@(posedge clk) disable iff (!rst_n)
    (nrt_q && !rd) |=> nrt_q); // R11
  AST_NRT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !overrun) |=> !nrt_q); // R11

endmodule

// File: rtl/acq_fsm.sv
module acq_fsm
  import acq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  acq_mode_t        mode,
  input  logic [CNT_W-1:0] pre_cnt,
  input  logic             ack,
  input  logic             smp_valid,
  input  logic             buf_start,
  input  logic             full_rise,
  output logic             smp_ready,
  output logic             arm_n,
  output logic             blk_ready
);

  acq_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] pre_q, pre_d;
  logic             trig_q, trig_d;
  logic             smp_fire;

  assign smp_ready = (state_q == ST_PRE) || (state_q == ST_ARMED) || (state_q == ST_FILL);
  assign smp_fire  = smp_valid && smp_ready;
  assign arm_n     = (state_q != ST_ARMED);
  assign blk_ready = (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pre_d   = pre_q;
    trig_d  = trig_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start && mode.en) begin
          // mode and count are frozen for the whole run
          trig_d = mode.trig;
          pre_d  = pre_cnt;
          cnt_d  = '0;
          if (!mode.trig)                        state_d = ST_FILL;
          else if (mode.pre && pre_cnt != '0)    state_d = ST_PRE;
          else                                   state_d = ST_ARMED;
        end
      end
      ST_PRE: begin
        if (smp_fire) begin
          if (cnt_q == pre_q - 1'b1) state_d = ST_ARMED;
          else                       cnt_d   = cnt_q + 1'b1;
        end
      end
      ST_ARMED: begin
        if (buf_start) state_d = ST_FILL;
      end
      ST_FILL: begin
        if (full_rise) state_d = ST_DONE;
      end
      ST_DONE: begin
        if (ack) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      pre_q   <= '0;
      trig_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      pre_q   <= pre_d;
      trig_q  <= trig_d;
    end
  end

  AST_START_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !(start && mode.en)) |=> state_q == ST_IDLE); // R2
  AST_FREE_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !trig_q) |-> arm_n); // R3
  AST_PRE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE && !smp_fire) |=> state_q == ST_PRE); // R4
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PRE) |-> cnt_q < pre_q); // R4
  AST_ARMED_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED && !buf_start) |=> !arm_n); // R6
  AST_BLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (blk_ready && !ack) |=> blk_ready); // R8
  AST_NO_SAMPLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |=> $stable(cnt_q) || state_q != ST_IDLE); // R9

endmodule

// File: rtl/acq_sequencer.sv
module acq_sequencer
  import acq_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int NBYTES     = (CNT_W + DATA_W - 1) / DATA_W,
  localparam int ADDR_W     = $clog2(NBYTES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic              stat_rd,
  output logic [DATA_W-1:0] stat_rdata,
  input  logic              start_req,
  input  logic              smp_valid,
  output logic              smp_ready,
  output logic              arm_n,
  input  logic              buf_start,
  input  logic              buf_full,
  output logic              blk_ready,
  input  logic              overrun
);

  acq_mode_t        mode;
  logic [CNT_W-1:0] pre_cnt;
  logic             ack;
  logic             full_rise;

  acq_cmd_regs #(
    .DATA_W(DATA_W), .CNT_W(CNT_W), .NBYTES(NBYTES), .ADDR_W(ADDR_W)
  ) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .addr(cfg_addr), .wdata(cfg_wdata),
    .mode(mode), .pre_cnt(pre_cnt), .ack(ack)
  );

  acq_sync_edge #(.STAGES(SYNC_STAGES)) u_full (
    .clk(clk), .rst_n(rst_n), .async_in(buf_full), .rise(full_rise)
  );

  acq_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start_req), .mode(mode), .pre_cnt(pre_cnt),
    .ack(ack), .smp_valid(smp_valid), .buf_start(buf_start), .full_rise(full_rise),
    .smp_ready(smp_ready), .arm_n(arm_n), .blk_ready(blk_ready)
  );

  acq_status #(.DATA_W(DATA_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .overrun(overrun), .rd(stat_rd),
    .blk_ready(blk_ready), .rdata(stat_rdata)
  );

  AST_READY_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    blk_ready |-> !smp_ready); // R9
  AST_ONE_HOT_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({!arm_n, blk_ready}) <= 1); // R6

endmodule

// File: tb/test_acq_sequencer.sv
module test_acq_sequencer;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       stat_rd = 1'b0;
  logic [7:0] stat_rdata;
  logic       start_req = 1'b0;
  logic       smp_valid = 1'b0;
  logic       smp_ready;
  logic       arm_n;
  logic       buf_start = 1'b0;
  logic       buf_full = 1'b0;
  logic       blk_ready;
  logic       overrun = 1'b0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic  arm_n;
    logic  blk;
    logic  rdy;
    string tag;
  } exp_t;
  exp_t exp_q[$];

  always #5 clk = ~clk;

  acq_sequencer i_acq_sequencer (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stat_rd(stat_rd), .stat_rdata(stat_rdata),
    .start_req(start_req), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .arm_n(arm_n), .buf_start(buf_start), .buf_full(buf_full),
    .blk_ready(blk_ready), .overrun(overrun)
  );

  // driver side: queue what the outputs must be after the coming edge
  task automatic tick(input logic a, input logic b, input logic r, input string tag);
    exp_t e;
    if (tag != "") begin
      e.arm_n = a; e.blk = b; e.rdy = r; e.tag = tag;
      exp_q.push_back(e);
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b0, 1'b0, "");
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    tick(1'b0, 1'b0, 1'b0, "");
    cfg_wr = 1'b0;
  endtask

  task automatic rd_stat(input logic [7:0] expv, input string tag);
    stat_rd = 1'b1;
    #1;
    checks++;
    if (stat_rdata !== expv) begin
      fails++;
      $display("FAIL %s status actual=%h expected=%h", tag, stat_rdata, expv);
    end
    @(posedge clk);
    @(negedge clk);
    stat_rd = 1'b0;
  endtask

  task automatic chk_bus(input logic [7:0] expv, input string tag);
    checks++;
    if (stat_rdata !== expv) begin
      fails++;
      $display("FAIL %s bus actual=%h expected=%h", tag, stat_rdata, expv);
    end
  endtask

  // monitor side: compare after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (arm_n !== e.arm_n || blk_ready !== e.blk || smp_ready !== e.rdy) begin
          fails++;
          $display("FAIL %s arm_n/blk/rdy actual=%b%b%b expected=%b%b%b",
                   e.tag, arm_n, blk_ready, smp_ready, e.arm_n, e.blk, e.rdy);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  // finish a running measurement: buffer-full edge then acknowledge
  task automatic complete(input logic [7:0] ctrl, input string tag);
    buf_full = 1'b1;
    tick(1'b1, 1'b0, 1'b1, tag);
    tick(1'b1, 1'b0, 1'b1, tag);
    tick(1'b1, 1'b1, 1'b0, tag);
    wr(2'd0, ctrl | 8'h01);
    buf_full = 1'b0;
    tick(1'b1, 1'b0, 1'b0, "R8");
    idle(2);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    // reset state
    tick(1'b1, 1'b0, 1'b0, "R2");
    chk_bus(8'h00, "R10");

    // R11 / R10: overrun flag behaviour
    overrun = 1'b1; tick(1'b1, 1'b0, 1'b0, "");
    overrun = 1'b0;
    chk_bus(8'h00, "R10");                 // flag set but no read strobe
    rd_stat(8'h01, "R11");
    rd_stat(8'h00, "R11");                 // cleared by previous read
    overrun = 1'b1; tick(1'b1, 1'b0, 1'b0, "");
    rd_stat(8'h01, "R11");                 // overrun still high during read
    overrun = 1'b0;
    rd_stat(8'h01, "R11");                 // set won over the clear
    rd_stat(8'h00, "R11");

    // R2: start without enable
    start_req = 1'b1; tick(1'b1, 1'b0, 1'b0, "R2");
    start_req = 1'b0; tick(1'b1, 1'b0, 1'b0, "R2");

    // R1: count 3 (low byte at address 1, high at 2), free-run enabled
    wr(2'd1, 8'd3);
    wr(2'd2, 8'd0);
    wr(2'd0, 8'h08);
    wr(2'd3, 8'h00);                        // other address must not disturb control

    // R3: free-run
    start_req = 1'b1; tick(1'b1, 1'b0, 1'b1, "R1");
    start_req = 1'b0;
    buf_start = 1'b1; smp_valid = 1'b1; tick(1'b1, 1'b0, 1'b1, "R3");
    buf_start = 1'b0; tick(1'b1, 1'b0, 1'b1, "R3");
    smp_valid = 1'b0;
    buf_full = 1'b1;
    tick(1'b1, 1'b0, 1'b1, "R7");
    tick(1'b1, 1'b0, 1'b1, "R7");
    tick(1'b1, 1'b1, 1'b0, "R7");
    tick(1'b1, 1'b1, 1'b0, "R8");
    start_req = 1'b1; tick(1'b1, 1'b1, 1'b0, "R8");  // start ignored while waiting ack
    start_req = 1'b0;
    rd_stat(8'h02, "R10");
    wr(2'd0, 8'h09);
    tick(1'b1, 1'b0, 1'b0, "R8");

    // R7: level already high at start does not complete
    start_req = 1'b1; tick(1'b1, 1'b0, 1'b1, "R7");
    start_req = 1'b0;
    for (int i = 0; i < 4; i++) tick(1'b1, 1'b0, 1'b1, "R7");
    buf_full = 1'b0;
    tick(1'b1, 1'b0, 1'b1, ""); tick(1'b1, 1'b0, 1'b1, "");
    complete(8'h08, "R7");

    // R4 / R9 / R6: triggered with pretrigger count 3
    wr(2'd0, 8'h0E);
    smp_valid = 1'b1;
    tick(1'b1, 1'b0, 1'b0, "R9");
    tick(1'b1, 1'b0, 1'b0, "R9");           // not counted: ready low
    smp_valid = 1'b0;
    start_req = 1'b1; tick(1'b1, 1'b0, 1'b1, "R4");
    start_req = 1'b0;
    buf_start = 1'b1; tick(1'b1, 1'b0, 1'b1, "R4"); // trigger ignored while counting
    buf_start = 1'b0;
    smp_valid = 1'b1;
    tick(1'b1, 1'b0, 1'b1, "R4");
    tick(1'b1, 1'b0, 1'b1, "R4");
    tick(1'b0, 1'b0, 1'b1, "R4");           // third sample arms
    smp_valid = 1'b0;
    buf_full = 1'b1;
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0, 1'b1, "R6");
    buf_full = 1'b0;
    for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 1'b1, "R6");
    buf_start = 1'b1; tick(1'b1, 1'b0, 1'b1, "R6");
    buf_start = 1'b0;
    complete(8'h0E, "R7");

    // R5: triggered without pretrigger
    wr(2'd0, 8'h0A);
    start_req = 1'b1; tick(1'b0, 1'b0, 1'b1, "R5");
    start_req = 1'b0;
    buf_start = 1'b1; tick(1'b1, 1'b0, 1'b1, "R6");
    buf_start = 1'b0;
    complete(8'h0A, "R5");

    // R5: pretrigger enabled but count zero
    wr(2'd1, 8'd0);
    wr(2'd0, 8'h0E);
    start_req = 1'b1; tick(1'b0, 1'b0, 1'b1, "R5");
    start_req = 1'b0;
    buf_start = 1'b1; tick(1'b1, 1'b0, 1'b1, "R6");
    buf_start = 1'b0;
    complete(8'h0E, "R5");

    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule